// File: doc/BRIEF.md
# Hot-Plug I/O Expander Bus Master

This block keeps an external I/O expander in step with a set of local hot-plug signals over a two-wire, open-drain serial bus of the SMBus/I2C kind. It watches an output image. Whenever any bit of that image changes, it sends the whole image to the expander in a write transaction. It also watches the expander's active-low interrupt line. While that line is asserted, it reads the expander's whole input image and loads it into a local register. The new register value is marked by a one-cycle strobe.

The block is the only master on its bus segment. It has no arbitration and does not support clock stretching. It drives the lines through open-drain enables and reads the data line back through one input. The bus clock runs only while a transaction is in progress. Each bus clock period lasts four phases, and a run-time divider value sets the length of one phase. Only one transaction is active at a time. A pending write has priority over a pending read.

Top module: `hpx_top`

## Requirements
- R1: While reset is asserted and just after it is released, both line enables are low (lines released), `busy`, `errFlag` and `inNew` are 0, and `inVec` is 0. The last-seen output image is reset to 0.
- R2: A change of `outVec` from the last-seen value starts a write. The write sends a START, then the address byte `{EXP_ADDR, 1'b0}`, then IMG_W/8 data bytes, then a STOP. The expander acknowledges each byte. Every byte is sent most significant bit first.
- R3: A write carries the complete image captured when it starts, not only the changed bits. Data byte k carries `outVec[8k+7:8k]`, so the least significant byte goes first.
- R4: An assertion of `irqN` (low), after a two-flop synchronizer, starts a read. The read sends the address byte `{EXP_ADDR, 1'b1}` and then receives IMG_W/8 bytes, least significant byte first. The master acknowledges every received byte except the last one, which it does not acknowledge.
- R5: `inVec` changes only at the end of a read that completed without error. In that same cycle `inNew` is 1, and `inNew` is 1 for exactly one cycle per such read.
- R6: When a write and a read are both pending, the write runs first.
- R7: If `outVec` changes while a transaction is running, another write follows that transaction. It carries the value `outVec` holds when it starts.
- R8: `irqN` is treated as a level. If it is still low when a read completes, another read follows.
- R9: A missing acknowledge from the expander, on the address byte or on a written data byte, ends the transaction with a STOP and sets `errFlag`. `errFlag` stays set until reset, and `inVec` is left unchanged.
- R10: While `busy` is 0 both line enables are 0, so the bus clock toggles only during a transaction.
- R11: During address and data bits, the data line changes only while the clock line is driven low. One bus clock period is 4*max(`quarterDiv`,1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| quarterDiv | input | DIV_W | Clock cycles per bus phase (0 acts as 1) |
| outVec | input | IMG_W | Local hot-plug output image to mirror |
| irqN | input | 1 | Expander interrupt, active low, asynchronous |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sclOe | output | 1 | Pull bus clock line low when 1 |
| sdaOe | output | 1 | Pull bus data line low when 1 |
| inVec | output | IMG_W | Last input image read from the expander |
| inNew | output | 1 | One-cycle strobe marking a new `inVec` |
| busy | output | 1 | A transaction is in progress |
| errFlag | output | 1 | Sticky flag set by a missing acknowledge |

## Verification
The bench attaches a behavioural expander to the bus. It goes after the order of data bytes and the master's acknowledge pattern on reads. A design that reversed the bytes, or that acknowledged the last byte, would show a swapped image or a wrong acknowledge record. It makes an output change and an interrupt pending at the same time, to catch a controller that serves the read first. It changes `outVec` in the middle of a transaction, to catch a design that drops the follow-up write or sends a stale image. It holds the interrupt low, to catch a design that treats it as an edge and reads only once. A refused address byte must set a sticky error and leave `inVec` alone; a design that loaded the input register anyway would show a corrupted image. It also measures the bus clock period at two divider settings.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_XFER,
    ST_STOP
  } hpxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic run;      // phase timer enabled
    logic load;     // capture image and address byte
    logic rd;       // direction for a load
    logic sample;   // data line sampled this cycle
    logic nextBit;  // advance to the next bit slot
    logic commit;   // publish the received image
  } hpxStrb_t;
endpackage

// File: rtl/hpx_dp.sv
module hpx_dp
  import hpx_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter logic [6:0] EXP_ADDR = 7'h20,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  hpxStrb_t         strb,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic [IMG_W-1:0] outVec,
  input  logic             sdaIn,
  output logic             tick,
  output logic [1:0]       ph,
  output logic             txBit,
  output logic             ackSlot,
  output logic             addrByte,
  output logic             lastByte,
  output logic [IMG_W-1:0] inVec
);
  localparam int NB = IMG_W / 8;
  localparam int BW = $clog2(NB + 1);

  logic [DIV_W-1:0] cnt;
  logic [3:0]       bitIdx;
  logic [BW-1:0]    byteIdx;
  logic [7:0]       txSr;
  logic [7:0]       rxByte;
  logic [IMG_W-1:0] txImg;
  logic [IMG_W-1:0] rxAcc;
  logic [IMG_W-1:0] inReg;

  assign tick = strb.run && (({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, quarterDiv});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      ph  <= '0;
    end else if (!strb.run) begin
      cnt <= '0;
      ph  <= '0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= ph + 2'd1;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      byteIdx <= '0;
      txSr    <= '0;
      txImg   <= '0;
      rxByte  <= '0;
      rxAcc   <= '0;
    end else begin
      if (strb.sample && !ackSlot) rxByte <= {rxByte[6:0], sdaIn};
      if (strb.load) begin
        txImg   <= outVec;
        txSr    <= {EXP_ADDR, strb.rd};
        bitIdx  <= '0;
        byteIdx <= '0;
      end else if (strb.nextBit) begin
        if (ackSlot) begin
          bitIdx  <= '0;
          byteIdx <= byteIdx + BW'(1);
          txSr    <= txImg[int'(byteIdx)*8 +: 8];
        end else begin
          bitIdx <= bitIdx + 4'd1;
          txSr   <= {txSr[6:0], 1'b0};
          if (bitIdx == 4'd7 && !addrByte)
            rxAcc[(int'(byteIdx)-1)*8 +: 8] <= rxByte;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inReg <= '0;
    else if (strb.commit) inReg <= rxAcc;
  end

  assign txBit    = txSr[7];
  assign ackSlot  = (bitIdx == 4'd8);
  assign addrByte = (byteIdx == '0);
  assign lastByte = (byteIdx == BW'(NB));
  assign inVec    = inReg;
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
  import hpx_pkg::*;
#(
  parameter int IMG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IMG_W-1:0] outVec,
  input  logic             irqN,
  input  logic             sdaIn,
  input  logic             tick,
  input  logic [1:0]       ph,
  input  logic             txBit,
  input  logic             ackSlot,
  input  logic             addrByte,
  input  logic             lastByte,
  output hpxStrb_t         strb,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             errFlag,
  output logic             inNew,
  output logic             dataPhase
);
  hpxState_t        state;
  logic [IMG_W-1:0] outPrev;
  logic             irqS1, irqS2;
  logic             wrPend, isRd, nackSeen;
  logic             irqAct, outChg, phEnd, nackHit, endFrame;

  assign irqAct   = !irqS2;
  assign outChg   = (outVec != outPrev);
  assign phEnd    = tick && (ph == 2'd3);
  assign endFrame = ackSlot && (nackSeen || lastByte);

  always_comb begin
    strb         = '0;
    strb.run     = (state != ST_IDLE);
    strb.load    = (state == ST_IDLE) && (wrPend || irqAct);
    strb.rd      = !wrPend;
    strb.sample  = (state == ST_XFER) && tick && (ph == 2'd2);
    strb.nextBit = (state == ST_XFER) && phEnd && !endFrame;
    strb.commit  = (state == ST_STOP) && phEnd && isRd && !nackSeen;
  end

  // expander must acknowledge the address byte and every written byte
  assign nackHit = strb.sample && ackSlot && (addrByte || !isRd) && sdaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      outPrev  <= '0;
      irqS1    <= 1'b1;
      irqS2    <= 1'b1;
      wrPend   <= 1'b0;
      isRd     <= 1'b0;
      nackSeen <= 1'b0;
      errFlag  <= 1'b0;
      inNew    <= 1'b0;
    end else begin
      irqS1   <= irqN;
      irqS2   <= irqS1;
      outPrev <= outVec;
      wrPend  <= (wrPend || outChg) && !(strb.load && !strb.rd);
      inNew   <= strb.commit;
      if (nackHit) errFlag <= 1'b1;
      if (strb.load) nackSeen <= 1'b0;
      else if (nackHit) nackSeen <= 1'b1;
      unique case (state)
        ST_IDLE:  if (strb.load) begin
                    isRd  <= strb.rd;
                    state <= ST_START;
                  end
        ST_START: if (phEnd) state <= ST_XFER;
        ST_XFER:  if (phEnd && endFrame) state <= ST_STOP;
        ST_STOP:  if (phEnd) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    unique case (state)
      ST_START: begin
        sclOe = (ph >= 2'd2);
        sdaOe = (ph >= 2'd1);
      end
      ST_XFER: begin
        sclOe = (ph == 2'd0) || (ph == 2'd3);
        if (ackSlot) sdaOe = isRd && !addrByte && !lastByte;
        else         sdaOe = (addrByte || !isRd) && !txBit;
      end
      ST_STOP: begin
        sclOe = (ph == 2'd0);
        sdaOe = (ph <= 2'd1);
      end
      default: ;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign dataPhase = (state == ST_XFER);
endmodule

// File: rtl/hpx_top.sv
module hpx_top
  import hpx_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter logic [6:0] EXP_ADDR = 7'h20,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic [IMG_W-1:0] outVec,
  input  logic             irqN,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic [IMG_W-1:0] inVec,
  output logic             inNew,
  output logic             busy,
  output logic             errFlag
);
  hpxStrb_t   strb;
  logic       tick, txBit, ackSlot, addrByte, lastByte, dataPhase;
  logic [1:0] ph;

  hpx_ctrl #(.IMG_W(IMG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .outVec(outVec), .irqN(irqN), .sdaIn(sdaIn),
    .tick(tick), .ph(ph), .txBit(txBit), .ackSlot(ackSlot),
    .addrByte(addrByte), .lastByte(lastByte), .strb(strb),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .errFlag(errFlag),
    .inNew(inNew), .dataPhase(dataPhase)
  );

  hpx_dp #(.IMG_W(IMG_W), .EXP_ADDR(EXP_ADDR), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .quarterDiv(quarterDiv),
    .outVec(outVec), .sdaIn(sdaIn), .tick(tick), .ph(ph), .txBit(txBit),
    .ackSlot(ackSlot), .addrByte(addrByte), .lastByte(lastByte),
    .inVec(inVec)
  );
endmodule

// File: rtl/hpx_chk.sv
module hpx_chk #(
  parameter int IMG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             busy,
  input logic             errFlag,
  input logic             inNew,
  input logic [IMG_W-1:0] inVec,
  input logic             dataPhase
);
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  // R11
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && $past(dataPhase) && !sclOe && !$past(sclOe)) |-> $stable(sdaOe));

  // R5
  in_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inVec) |-> inNew);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    inNew |=> !inNew);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind hpx_top hpx_chk #(.IMG_W(IMG_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy),
  .errFlag(errFlag), .inNew(inNew), .inVec(inVec), .dataPhase(dataPhase)
);

// File: tb/sim_hpx_top.sv
module sim_hpx_top;
  localparam int IMG_W = 16;
  localparam int NB = IMG_W / 8;
  localparam logic [6:0] ADDR = 7'h20;
  localparam logic [31:0] VECS [0:3] = '{
    32'h0001_FFFF, 32'h8000_0000, 32'hA55A_5AA5, 32'hFFFF_0100
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] quarterDiv = 8'd2;
  logic [IMG_W-1:0] outVec = '0;
  logic irqN = 1'b1;
  logic sclOe, sdaOe, inNew, busy, errFlag;
  logic [IMG_W-1:0] inVec;
  logic slvOe = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = !sclOe;
  assign sdaBus = !(sdaOe || slvOe);

  hpx_top #(.IMG_W(IMG_W), .EXP_ADDR(ADDR), .DIV_W(8)) u0 (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .outVec(outVec),
    .irqN(irqN), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe),
    .inVec(inVec), .inNew(inNew), .busy(busy), .errFlag(errFlag)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, newCnt = 0, idleBad = 0, cycCnt = 0;
  int wrCnt = 0, rdCnt = 0;
  logic nackAddr = 1'b0, holdIrq = 1'b0;
  logic [IMG_W-1:0] rdImg = '0, wrImg = '0, lastWr = '0;
  logic [7:0] lastAddrW = '0, lastAddrR = '0;
  logic [NB-1:0] mAck = '0;
  bit done = 1'b0;

  always @(posedge clk) cycCnt++;
  always @(negedge clk) if (inNew) newCnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural expander
  task automatic get8(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclBus);
      b = {b[6:0], sdaBus};
    end
  endtask

  task automatic slvFrame();
    logic [7:0] b;
    get8(b);
    @(negedge sclBus);
    if (b[7:1] != ADDR || nackAddr) return;
    slvOe = 1'b1;
    if (b[0]) begin
      rdCnt++;
      lastAddrR = b;
      if (!holdIrq) irqN = 1'b1;
      for (int k = 0; k < NB; k++) begin
        for (int i = 7; i >= 0; i--) begin
          @(negedge sclBus);
          slvOe = !rdImg[k*8+i];
          @(posedge sclBus);
        end
        @(negedge sclBus);
        slvOe = 1'b0;
        @(posedge sclBus);
        mAck[k] = !sdaBus;
      end
    end else begin
      lastAddrW = b;
      for (int k = 0; k < NB; k++) begin
        @(negedge sclBus);
        slvOe = 1'b0;
        get8(b);
        wrImg[k*8 +: 8] = b;
        @(negedge sclBus);
        slvOe = 1'b1;
      end
      @(negedge sclBus);
      slvOe = 1'b0;
      lastWr = wrImg;
      wrCnt++;
    end
  endtask

  initial begin
    forever begin
      @(negedge sdaBus);
      if (sclBus) slvFrame();
    end
  end

  task automatic waitQuiet();
    int q = 0;
    int n = 0;
    while (q < 4 && n < 20000) begin
      @(negedge clk);
      n++;
      if (busy) q = 0;
      else begin
        q++;
        if (sclOe || sdaOe) idleBad++;
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finish");
      summary();
    end
  end

  initial begin
    int w0, r0, n0, t0, t1;
    logic [IMG_W-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    chk("R1 scl", {31'b0, sclOe}, 0);
    chk("R1 sda", {31'b0, sdaOe}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 err", {31'b0, errFlag}, 0);
    chk("R1 inVec", 32'(inVec), 0);
    chk("R1 inNew", {31'b0, inNew}, 0);

    // vector table: write then read
    foreach (VECS[e]) begin
      w0 = wrCnt;
      outVec = VECS[e][31:16];
      repeat (6) @(negedge clk);
      waitQuiet();
      chk("R3 image", 32'(lastWr), 32'(VECS[e][31:16]));
      chk("R2 addr", 32'(lastAddrW), {24'b0, ADDR, 1'b0});
      chk("R2 count", wrCnt, w0 + 1);
      n0 = newCnt;
      keep = inVec;
      rdImg = VECS[e][15:0];
      irqN = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5 early", 32'(inVec), 32'(keep));
      waitQuiet();
      chk("R4 image", 32'(inVec), 32'(VECS[e][15:0]));
      chk("R4 addr", 32'(lastAddrR), {24'b0, ADDR, 1'b1});
      chk("R4 ack", 32'(mAck), 32'({1'b0, {(NB-1){1'b1}}}));
      chk("R5 strobe", newCnt, n0 + 1);
    end

    // R6 write wins over a read pending at the same time
    w0 = wrCnt; r0 = rdCnt;
    rdImg = 16'h3C3C;
    irqN = 1'b0;
    @(negedge clk);
    outVec = 16'h1357;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    chk("R6 write first", wrCnt, w0 + 1);
    chk("R6 read later", rdCnt, r0);
    waitQuiet();
    chk("R6 read done", rdCnt, r0 + 1);
    chk("R6 in", 32'(inVec), 32'h3C3C);

    // R7 change in the middle of a write
    w0 = wrCnt;
    outVec = 16'h2222;
    repeat (40) @(negedge clk);
    chk("R7 busy", {31'b0, busy}, 1);
    outVec = 16'h4444;
    waitQuiet();
    chk("R7 count", wrCnt, w0 + 2);
    chk("R7 newest", 32'(lastWr), 32'h4444);

    // R8 interrupt held low gives repeated reads
    r0 = rdCnt;
    holdIrq = 1'b1;
    rdImg = 16'h0F0F;
    irqN = 1'b0;
    for (int n = 0; n < 5000 && rdCnt < r0 + 2; n++) @(negedge clk);
    irqN = 1'b1;
    holdIrq = 1'b0;
    waitQuiet();
    chk("R8 reads", {31'b0, rdCnt >= r0 + 2}, 1);
    chk("R8 in", 32'(inVec), 32'h0F0F);

    // R11 clock period at two divider settings
    foreach (VECS[e]) if (e < 2) begin
      quarterDiv = (e == 0) ? 8'd1 : 8'd3;
      outVec = outVec ^ 16'h00F0;
      @(posedge sclBus); t0 = cycCnt;
      @(posedge sclBus); t1 = cycCnt;
      waitQuiet();
      chk("R11 period", t1 - t0, 4 * int'(quarterDiv));
      chk("R11 data", 32'(lastWr), 32'(outVec));
    end
    quarterDiv = 8'd2;
    chk("R10 idle lines", idleBad, 0);

    // R9 refused address
    w0 = wrCnt; n0 = newCnt;
    nackAddr = 1'b1;
    outVec = 16'h7777;
    repeat (6) @(negedge clk);
    waitQuiet();
    chk("R9 err", {31'b0, errFlag}, 1);
    chk("R9 no write", wrCnt, w0);
    keep = inVec;
    rdImg = 16'hDEAD;
    irqN = 1'b0;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    irqN = 1'b1;
    waitQuiet();
    chk("R9 in kept", 32'(inVec), 32'(keep));
    chk("R9 no strobe", newCnt, n0);
    nackAddr = 1'b0;
    outVec = 16'h0808;
    repeat (6) @(negedge clk);
    waitQuiet();
    chk("R9 sticky", {31'b0, errFlag}, 1);
    chk("R9 recovers", 32'(lastWr), 32'h0808);

    done = 1'b1;
    summary();
  end
endmodule